// File: doc/BRIEF.md
# Configuration Fault Injection Sequencer

This block drives one single-bit upset experiment on a reconfigurable circuit at a time. After a start pulse it lets the circuit under test run for a pseudo-randomly chosen number of enabled cycles. It then withdraws the circuit's clock enable and writes a corrupted copy of the fault-free partial image to a configuration write port. In that copy exactly one bit is inverted. The circuit then resumes and runs to the end of its fixed run length. When the run is over, the clock stays off while the complete fault-free image is written again, so an upset never survives into the next run. A one-cycle done pulse closes the run.

Two independent linear feedback shift registers step on every clock. One supplies the injection cycle. The other supplies an index into an external table that lists the configuration bit positions worth upsetting. A value outside the valid range is masked down to a power-of-two width. If it is still too large, it is discarded and the next value is tried. The fault-free image lives in an external word memory with a combinational read port. The table is read through a synchronous port with one cycle of latency. Each configuration word is offered with valid/ready handshaking and holds still until it is taken.

Top module: `cfg_fault_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, `cut_ce_o`, `cfg_valid_o`, `done_o` and `tbl_rd_o` are all 0.
- R2: A start pulse in the idle state raises `tbl_rd_o` for that one cycle, with `tbl_addr_o` below TABLE_DEPTH. A start pulse in any other state has no effect: no table read, and the current run is not lengthened or restarted.
- R3: Each run gives the circuit exactly RUN_CYCLES enabled cycles. Of these, the number before the first configuration word lies in 0..RUN_CYCLES-1.
- R4: `cut_ce_o` is 0 in every cycle in which `cfg_valid_o` is 1.
- R5: The first image written in a run holds BS_WORDS words, sent with `cfg_addr_o` = 0, 1, … in order. Take P as the table entry. Word P/32 differs from the fault-free word only at bit P%32, where bit 0 is the LSB. All other words are unmodified.
- R6: The inverted position P is the table entry returned for the index that was read at start, one cycle after the read.
- R7: After the circuit's last enabled cycle, all BS_WORDS words are written again, in order and unmodified.
- R8: While `cfg_valid_o` is 1 and `cfg_ready_i` is 0, the next cycle keeps `cfg_valid_o` at 1 with the same `cfg_addr_o` and `cfg_data_o`.
- R9: `done_o` pulses for one cycle after the last restoring word is accepted. The block is then idle and accepts the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a run (honoured only when idle) |
| done_o | output | 1 | One-cycle end-of-run pulse |
| cut_ce_o | output | 1 | Clock enable for the circuit under test |
| tbl_rd_o | output | 1 | Table read strobe |
| tbl_addr_o | output | IDX_W | Table index |
| tbl_data_i | input | POS_W | Bit position, valid one cycle after the read |
| gold_addr_o | output | WIDX_W | Fault-free image word address |
| gold_data_i | input | 32 | Fault-free image word (combinational) |
| cfg_valid_o | output | 1 | Configuration word valid |
| cfg_ready_i | input | 1 | Configuration port ready |
| cfg_addr_o | output | WIDX_W | Word index of the offered word |
| cfg_data_o | output | 32 | Offered configuration word |

## Verification
The bench first runs several directed tables in which every entry names the same position: the first bit of the image, the last bit, and the first bit of the second word. These separate an error in the word index from an error in the bit offset, and they expose off-by-one errors at word edges. It then runs tables of random positions, so the read index can be matched to the flipped bit. The ready input is driven by an always-ready pattern and by sparse random patterns. The always-ready pattern checks back-to-back word order. The sparse patterns check that stalled words hold steady and that the clock stays off for a stretched write. Spurious start pulses in the middle of a run show whether the sequence is disturbed.

// File: rtl/cfs_pkg.sv
package cfs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RUN_PRE,
        ST_STOP_CLK,
        ST_WRITE_FAULTY,
        ST_RUN_POST,
        ST_RESTORE,
        ST_DONE
    } state_e;

    typedef struct packed {
        logic active;
        logic flip_en;
    } stream_ctl_t;

    function automatic logic [31:0] bit_mask(input logic [4:0] b);
        return 32'd1 << b;
    endfunction

endpackage

// File: rtl/cfs_lfsr.sv
module cfs_lfsr #(
    parameter int          W     = 16,
    parameter int          OUT_W = 8,
    parameter logic [W-1:0] TAPS = 16'hB400,
    parameter logic [W-1:0] SEED = 16'h0001
) (
    input  logic             clk,
    input  logic             rst,
    output logic [OUT_W-1:0] value_o
);
    logic [W-1:0] state_q;

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= SEED;
        else if (state_q[0])
            state_q <= (state_q >> 1) ^ TAPS;
        else
            state_q <= state_q >> 1;
    end

    assign value_o = state_q[OUT_W-1:0];
endmodule

// File: rtl/cfs_stream.sv
module cfs_stream
    import cfs_pkg::*;
#(
    parameter int BS_WORDS = 12,
    localparam int WIDX_W  = $clog2(BS_WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  stream_ctl_t       ctl_i,
    input  logic [WIDX_W-1:0] flip_word_i,
    input  logic [4:0]        flip_bit_i,
    input  logic [31:0]       gold_data_i,
    input  logic              ready_i,
    output logic              valid_o,
    output logic [WIDX_W-1:0] addr_o,
    output logic [31:0]       data_o,
    output logic              last_o
);
    localparam logic [WIDX_W-1:0] LAST_IDX = WIDX_W'(BS_WORDS - 1);

    logic [WIDX_W-1:0] widx_q;
    logic              hit;

    assign valid_o = ctl_i.active;
    assign addr_o  = widx_q;
    assign hit     = ctl_i.flip_en && (widx_q == flip_word_i);
    assign data_o  = hit ? (gold_data_i ^ bit_mask(flip_bit_i)) : gold_data_i;
    assign last_o  = valid_o && ready_i && (widx_q == LAST_IDX);

    always_ff @(posedge clk) begin
        if (rst)
            widx_q <= '0;
        else if (valid_o && ready_i)
            widx_q <= (widx_q == LAST_IDX) ? '0 : widx_q + 1'b1;
    end
endmodule

// File: rtl/cfg_fault_seq.sv
module cfg_fault_seq
    import cfs_pkg::*;
#(
    parameter int BS_WORDS    = 12,
    parameter int TABLE_DEPTH = 6,
    parameter int RUN_CYCLES  = 40,
    parameter int LFSR_W      = 16,
    localparam int WIDX_W     = $clog2(BS_WORDS),
    localparam int POS_W      = WIDX_W + 5,
    localparam int IDX_W      = $clog2(TABLE_DEPTH),
    localparam int TIME_W     = $clog2(RUN_CYCLES),
    localparam int CNT_W      = $clog2(RUN_CYCLES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    output logic              done_o,
    output logic              cut_ce_o,
    output logic              tbl_rd_o,
    output logic [IDX_W-1:0]  tbl_addr_o,
    input  logic [POS_W-1:0]  tbl_data_i,
    output logic [WIDX_W-1:0] gold_addr_o,
    input  logic [31:0]       gold_data_i,
    output logic              cfg_valid_o,
    input  logic              cfg_ready_i,
    output logic [WIDX_W-1:0] cfg_addr_o,
    output logic [31:0]       cfg_data_o
);
    localparam logic [CNT_W-1:0] RUN_LIM = CNT_W'(RUN_CYCLES);
    localparam logic [IDX_W:0]   TBL_LIM = (IDX_W+1)'(TABLE_DEPTH);

    state_e            state_q;
    logic [CNT_W-1:0]  cnt_q, inj_q, cand_time_q;
    logic [IDX_W-1:0]  cand_idx_q;
    logic [POS_W-1:0]  pos_q;
    logic              rd_q;
    logic [TIME_W-1:0] t_raw;
    logic [IDX_W-1:0]  i_raw;
    logic              last_beat;
    stream_ctl_t       sctl;

    // Two independent draw sources (injection time, table index)
    cfs_lfsr #(.W(LFSR_W), .OUT_W(TIME_W), .TAPS(16'hB400), .SEED(16'hACE1))
        u_lfsr_time (.clk(clk), .rst(rst), .value_o(t_raw));
    cfs_lfsr #(.W(LFSR_W), .OUT_W(IDX_W), .TAPS(16'hD008), .SEED(16'h1F35))
        u_lfsr_idx (.clk(clk), .rst(rst), .value_o(i_raw));

    // Keep the latest in-range draw; out-of-range values are discarded
    always_ff @(posedge clk) begin
        if (rst) begin
            cand_time_q <= '0;
            cand_idx_q  <= '0;
        end else begin
            if (CNT_W'(t_raw) < RUN_LIM)
                cand_time_q <= CNT_W'(t_raw);
            if ({1'b0, i_raw} < TBL_LIM)
                cand_idx_q <= i_raw;
        end
    end

    assign tbl_rd_o   = (state_q == ST_IDLE) && start_i;
    assign tbl_addr_o = cand_idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q  <= 1'b0;
            pos_q <= '0;
        end else begin
            rd_q <= tbl_rd_o;
            if (rd_q)
                pos_q <= tbl_data_i;
        end
    end

    assign sctl.active  = (state_q == ST_WRITE_FAULTY) || (state_q == ST_RESTORE);
    assign sctl.flip_en = (state_q == ST_WRITE_FAULTY);

    cfs_stream #(.BS_WORDS(BS_WORDS)) u_stream (
        .clk         (clk),
        .rst         (rst),
        .ctl_i       (sctl),
        .flip_word_i (pos_q[POS_W-1:5]),
        .flip_bit_i  (pos_q[4:0]),
        .gold_data_i (gold_data_i),
        .ready_i     (cfg_ready_i),
        .valid_o     (cfg_valid_o),
        .addr_o      (cfg_addr_o),
        .data_o      (cfg_data_o),
        .last_o      (last_beat)
    );
    assign gold_addr_o = cfg_addr_o;

    assign cut_ce_o = ((state_q == ST_RUN_PRE)  && (cnt_q != inj_q)) ||
                      ((state_q == ST_RUN_POST) && (cnt_q != RUN_LIM));
    assign done_o   = (state_q == ST_DONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            inj_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start_i) begin
                    state_q <= ST_RUN_PRE;
                    cnt_q   <= '0;
                    inj_q   <= cand_time_q;
                end
                ST_RUN_PRE:
                    if (cnt_q == inj_q) state_q <= ST_STOP_CLK;
                    else                cnt_q   <= cnt_q + 1'b1;
                ST_STOP_CLK:     state_q <= ST_WRITE_FAULTY;
                ST_WRITE_FAULTY: if (last_beat) state_q <= ST_RUN_POST;
                ST_RUN_POST:
                    if (cnt_q == RUN_LIM) state_q <= ST_RESTORE;
                    else                  cnt_q   <= cnt_q + 1'b1;
                ST_RESTORE:      if (last_beat) state_q <= ST_DONE;
                ST_DONE:         state_q <= ST_IDLE;
                default:         state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/cfs_chk.sv
module cfs_chk
    import cfs_pkg::*;
#(
    parameter int RUN_CYCLES = 40,
    parameter int WIDX_W     = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              cut_ce_o,
    input logic              tbl_rd_o,
    input logic              cfg_valid_o,
    input logic              cfg_ready_i,
    input logic [WIDX_W-1:0] cfg_addr_o,
    input logic [31:0]       cfg_data_o,
    input logic [31:0]       gold_data_i,
    input logic              done_o,
    input state_e            state_q
);
    int unsigned ce_cnt;

    always_ff @(posedge clk) begin
        if (rst || tbl_rd_o) ce_cnt <= 0;
        else if (cut_ce_o)   ce_cnt <= ce_cnt + 1;
    end

    // R2
    tbl_read_idle_chk: assert property (@(posedge clk) disable iff (rst)
        tbl_rd_o |-> (state_q == ST_IDLE));
    // R3
    ce_budget_chk: assert property (@(posedge clk) disable iff (rst)
        ce_cnt <= RUN_CYCLES);
    // R4
    ce_off_write_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_valid_o |-> !cut_ce_o);
    // R5
    single_flip_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_valid_o |-> ($countones(cfg_data_o ^ gold_data_i) <= 1));
    // R7
    clean_restore_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_valid_o && state_q == ST_RESTORE) |-> (cfg_data_o == gold_data_i));
    // R8
    hold_word_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_valid_o && !cfg_ready_i) |=>
            (cfg_valid_o && $stable(cfg_data_o) && $stable(cfg_addr_o)));
    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> (!done_o && state_q == ST_IDLE));
endmodule

bind cfg_fault_seq cfs_chk #(.RUN_CYCLES(RUN_CYCLES), .WIDX_W(WIDX_W)) u_chk (
    .clk(clk), .rst(rst), .cut_ce_o(cut_ce_o), .tbl_rd_o(tbl_rd_o),
    .cfg_valid_o(cfg_valid_o), .cfg_ready_i(cfg_ready_i),
    .cfg_addr_o(cfg_addr_o), .cfg_data_o(cfg_data_o),
    .gold_data_i(gold_data_i), .done_o(done_o), .state_q(state_q)
);

// File: tb/cfg_fault_seq_tb.sv
module cfg_fault_seq_tb;
    localparam int BS  = 12;
    localparam int TD  = 6;
    localparam int RC  = 40;
    localparam int WW  = $clog2(BS);
    localparam int PW  = WW + 5;
    localparam int IW  = $clog2(TD);

    logic clk = 0, rst = 1, start = 0;
    logic done, ce, tbl_rd, cfg_valid, cfg_ready = 0;
    logic [IW-1:0] tbl_addr;
    logic [PW-1:0] tbl_data;
    logic [WW-1:0] gold_addr, cfg_addr;
    logic [31:0]   gold_data, cfg_data;

    always #4 clk = ~clk;

    cfg_fault_seq #(.BS_WORDS(BS), .TABLE_DEPTH(TD), .RUN_CYCLES(RC)) u_dut (
        .clk(clk), .rst(rst), .start_i(start), .done_o(done), .cut_ce_o(ce),
        .tbl_rd_o(tbl_rd), .tbl_addr_o(tbl_addr), .tbl_data_i(tbl_data),
        .gold_addr_o(gold_addr), .gold_data_i(gold_data),
        .cfg_valid_o(cfg_valid), .cfg_ready_i(cfg_ready),
        .cfg_addr_o(cfg_addr), .cfg_data_o(cfg_data)
    );

    logic [31:0] gold [BS];
    int          table_m [TD];
    assign gold_data = gold[gold_addr];
    always @(posedge clk) tbl_data <= PW'(table_m[tbl_addr]);

    int n_checks = 0, n_fail = 0;
    int ready_pct = 100;
    int nw, ce_tot, ce_pre, n_rd, rd_idx, n_done, ce_err, stall_err, bad_idx;
    logic [WW-1:0] w_addr [2*BS];
    logic [31:0]   w_data [2*BS];
    logic          stall_p;
    logic [WW-1:0] st_addr;
    logic [31:0]   st_data;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: outputs at negedge hold the values seen at the next posedge
    always @(negedge clk) begin
        if (!rst) begin
            cfg_ready = (($urandom % 100) < ready_pct);
            if (stall_p && (!cfg_valid || cfg_addr != st_addr || cfg_data != st_data))
                stall_err++;
            stall_p = cfg_valid && !cfg_ready;
            st_addr = cfg_addr; st_data = cfg_data;
            if (cfg_valid && ce) ce_err++;
            if (ce) begin
                ce_tot++;
                if (nw == 0) ce_pre++;
            end
            if (tbl_rd) begin
                n_rd++;
                rd_idx = int'(tbl_addr);
                if (int'(tbl_addr) >= TD) bad_idx++;
            end
            if (cfg_valid && cfg_ready && nw < 2*BS) begin
                w_addr[nw] = cfg_addr; w_data[nw] = cfg_data; nw++;
            end
            if (done) n_done++;
        end
    end

    task automatic do_run(input int spur);
        int lim, pos;
        logic [31:0] exp;
        nw = 0; ce_tot = 0; ce_pre = 0; n_rd = 0; n_done = 0;
        ce_err = 0; stall_err = 0; bad_idx = 0; stall_p = 0;
        @(negedge clk) start = 1;
        @(negedge clk) start = 0;
        if (spur > 0) begin
            repeat (spur) @(negedge clk);
            start = 1; @(negedge clk) start = 0;
        end
        lim = 0;
        while (n_done == 0 && lim < 3000) begin @(negedge clk); lim++; end
        chk(lim < 3000, "R9 watchdog", lim, 0);
        @(negedge clk);
        chk(n_done == 1 && !done, "R9 single done pulse", n_done, 1);
        chk(n_rd == 1 && bad_idx == 0, "R2 one in-range table read", n_rd, 1);
        chk(ce_tot == RC, "R3 enabled cycles per run", ce_tot, RC);
        chk(ce_pre < RC, "R3 injection cycle range", ce_pre, RC - 1);
        chk(ce_err == 0, "R4 clock off while writing", ce_err, 0);
        chk(stall_err == 0, "R8 word held while stalled", stall_err, 0);
        chk(nw == 2*BS, "R7 word count", nw, 2*BS);
        pos = table_m[rd_idx];
        for (int w = 0; w < BS; w++) begin
            exp = gold[w] ^ ((w == pos / 32) ? (32'd1 << (pos % 32)) : 32'd0);
            chk(w_addr[w] == WW'(w) && w_data[w] == exp, "R5 R6 faulty word", w_data[w], exp);
        end
        for (int w = 0; w < BS; w++)
            chk(w_addr[BS+w] == WW'(w) && w_data[BS+w] == gold[w], "R7 restore word",
                w_data[BS+w], gold[w]);
    endtask

    initial begin
        void'($urandom(32'd4242));
        for (int w = 0; w < BS; w++) gold[w] = $urandom;
        for (int t = 0; t < TD; t++) table_m[t] = 0;
        repeat (3) @(negedge clk);
        chk(!ce && !cfg_valid && !done && !tbl_rd, "R1 reset outputs", {ce, cfg_valid, done, tbl_rd}, 0);
        rst = 0;
        @(negedge clk);
        chk(!ce && !cfg_valid && !done && !tbl_rd, "R1 after reset", {ce, cfg_valid, done, tbl_rd}, 0);
        // Directed corners: first bit, last bit, word boundary
        do_run(0);
        for (int t = 0; t < TD; t++) table_m[t] = BS*32 - 1;
        ready_pct = 30; do_run(0);
        for (int t = 0; t < TD; t++) table_m[t] = 32;
        ready_pct = 100; do_run(0);
        // R2: start ignored mid-run
        for (int t = 0; t < TD; t++) table_m[t] = $urandom % (BS*32);
        do_run(5);
        do_run(60);
        // Random tables and ready patterns
        for (int r = 0; r < 25; r++) begin
            for (int t = 0; t < TD; t++) table_m[t] = $urandom % (BS*32);
            ready_pct = (r % 3 == 0) ? 100 : 20 + ($urandom % 70);
            repeat ($urandom % 7) @(negedge clk);
            do_run((r % 5 == 4) ? 3 + ($urandom % 40) : 0);
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule